// File: doc/BRIEF.md
# Two-Wire Write-Only Control Register Slave

This block is the slave side of a two-wire control port. The bus has a clock line and a shared open-drain data line. The block samples both lines into its own system clock and looks for start and stop conditions. It then takes in a three-byte write: a device address byte, then two bytes that together form a 16-bit control word. The upper 7 bits of that word name a register and the lower 9 bits are the value to store.

The device address is one of two fixed 7-bit values, and a strap input picks which one. The block acknowledges each byte by pulling the data line low, but only once its own address has matched. After the last byte is acknowledged, it commits the word to an internal bank of 9-bit registers and pulses a one-cycle write strobe. A start or stop condition that arrives in the middle of a transfer throws the transfer away. The block then waits idle for a fresh start.

Top module: `tw_ctl_slave`

## Requirements
- R1: Synchronous active-high reset clears every bank register to zero and holds `sda_oe` and `wr_stb` low.
- R2: From idle, a start condition begins a transfer. A start condition is the data line falling while the clock line is high. Data bits are sampled on rising clock-line edges, most significant bit first.
- R3: A start or stop condition seen during a transfer, before the acknowledge of the third byte has ended, returns the block to idle. No strobe is issued and the bank is left unchanged.
- R4: The first byte is the 7-bit device address followed by a direction bit in bit 0, which must be 0. The expected address is 0011010 with `addr_sel` low and 0011011 with `addr_sel` high. On a match, `sda_oe` goes high after the clock-line fall that ends the eighth bit and stays high until the fall that ends the ninth clock.
- R5: A first byte that does not match, including a direction bit of 1, gets no acknowledge. The block goes idle, so later bytes are not acknowledged and nothing is written.
- R6: After a matching first byte, the second and third bytes are each acknowledged on their ninth clock in the same way.
- R7: The control word is the second byte followed by the third byte. Bits 15:9 form `wr_addr` and bits 8:0 form `wr_data`. Both are valid while `wr_stb` is high. `wr_stb` is high for exactly one cycle, after the ninth-clock fall of the third byte.
- R8: The bank holds NUM_REGS registers of 9 bits each. Register i appears on `reg_q[9*i+8 : 9*i]`. A strobe whose address is below NUM_REGS stores the data there. A strobe with a higher address changes no register.
- R9: After a completed transfer the block is idle. Clock pulses that come without a new start condition are not acknowledged and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| addr_sel | input | 1 | Strap that selects between the two device addresses |
| wr_stb | output | 1 | One-cycle strobe for a committed control word |
| wr_addr | output | 7 | Register address of the committed word |
| wr_data | output | 9 | Data of the committed word |
| reg_q | output | NUM_REGS*9 | Packed contents of the register bank |

## Verification
The bench sweeps all 128 device addresses under both strap values. A design with a wrong address constant, or one that ignored the strap or the direction bit, would acknowledge the wrong byte or miss the right one. It aborts transfers with a stop in the middle of a byte and with a repeated start after an acknowledged byte. A design that ignored those conditions would later commit a stale or mixed word. It writes every register with values computed from its index and one address outside the bank. This exposes swapped address and data fields, a bit order reversed from most significant first, or a write to an out-of-range address that wraps onto a real register. Finally it clocks a byte after a completed transfer with no start. A block that stayed armed would acknowledge that byte or strobe a second time.

// File: rtl/tw_ctl_pkg.sv
package tw_ctl_pkg;

    localparam int RADDR_W = 7;
    localparam int RDATA_W = 9;
    localparam int WORD_W  = RADDR_W + RDATA_W;
    localparam int BYTE_W  = 8;
    localparam int DEV_W   = 7;

    localparam logic [DEV_W-1:0] DEV_BASE = 7'b0011010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_HI,
        ST_HI_ACK,
        ST_LO,
        ST_LO_ACK
    } rx_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic [RADDR_W-1:0] addr;
        logic [RDATA_W-1:0] data;
    } ctl_word_t;

    // Device address: strap replaces the least significant address bit.
    function automatic logic [DEV_W-1:0] dev_addr(input logic sel);
        return {DEV_BASE[DEV_W-1:1], sel};
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync
    import tw_ctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prev;
    logic              sda_prev;

    // Synchroniser chains, reset to the idle (released) bus level.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_ff[g] <= scl_i;
                    sda_ff[g] <= sda_i;
                end else begin
                    scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
                    sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_ff[STAGES-1];
            sda_prev <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_ff[STAGES-1];
        ev.sda      = sda_ff[STAGES-1];
        ev.scl_rise =  scl_ff[STAGES-1] & ~scl_prev;
        ev.scl_fall = ~scl_ff[STAGES-1] &  scl_prev;
        ev.start    =  scl_ff[STAGES-1] & scl_prev & ~sda_ff[STAGES-1] &  sda_prev;
        ev.stop     =  scl_ff[STAGES-1] & scl_prev &  sda_ff[STAGES-1] & ~sda_prev;
    end

endmodule

// File: rtl/tw_frame_rx.sv
module tw_frame_rx
    import tw_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_ev_t   ev,
    input  logic      addr_sel,
    output logic      sda_oe,
    output logic      wr_stb,
    output ctl_word_t word
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    rx_state_t          state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  hi_q;
    logic               in_xfer;
    logic               byte_done;
    logic               dev_hit;

    assign in_xfer   = (state != ST_IDLE);
    assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
    assign dev_hit   = (shreg == {dev_addr(addr_sel), 1'b0});

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            hi_q    <= '0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            word    <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (ev.start && !in_xfer) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if ((ev.start || ev.stop) && in_xfer) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_HI, ST_LO: begin
                        if (ev.scl_rise && !byte_done) begin
                            shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.scl_fall && byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV) begin
                                if (dev_hit) begin
                                    state  <= ST_DEV_ACK;
                                    sda_oe <= 1'b1;
                                end else begin
                                    state  <= ST_IDLE;
                                end
                            end else if (state == ST_HI) begin
                                hi_q   <= shreg;
                                state  <= ST_HI_ACK;
                                sda_oe <= 1'b1;
                            end else begin
                                word   <= ctl_word_t'({hi_q, shreg});
                                state  <= ST_LO_ACK;
                                sda_oe <= 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_HI_ACK, ST_LO_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            if (state == ST_DEV_ACK) begin
                                state <= ST_HI;
                            end else if (state == ST_HI_ACK) begin
                                state <= ST_LO;
                            end else begin
                                state  <= ST_IDLE;
                                wr_stb <= 1'b1;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R7: the strobe is a single-cycle pulse
    assert_stb_single_R7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R7: a strobe only follows the third-byte acknowledge
    assert_stb_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ($past(state) == ST_LO_ACK));

    // R3: a stop during a transfer returns to idle
    assert_stop_abort_R3: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && in_xfer) |=> (state == ST_IDLE && !sda_oe));

    // R4: the acknowledge drive never moves while the clock line stays high
    assert_oe_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl)) |-> $stable(sda_oe));

endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
    import tw_ctl_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  ctl_word_t                   word,
    output logic [NUM_REGS*RDATA_W-1:0] reg_q
);

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    reg_q[i*RDATA_W +: RDATA_W] <= '0;
                end else if (wr_en && word.addr == RADDR_W'(i)) begin
                    reg_q[i*RDATA_W +: RDATA_W] <= word.data;
                end
            end
        end
    endgenerate

    // R8: without a strobe the bank contents hold
    assert_bank_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(reg_q));

endmodule

// File: rtl/tw_ctl_slave.sv
module tw_ctl_slave
    import tw_ctl_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe,
    input  logic                        addr_sel,
    output logic                        wr_stb,
    output logic [RADDR_W-1:0]          wr_addr,
    output logic [RDATA_W-1:0]          wr_data,
    output logic [NUM_REGS*RDATA_W-1:0] reg_q
);

    bus_ev_t   ev;
    ctl_word_t word;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    tw_frame_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .wr_stb   (wr_stb),
        .word     (word)
    );

    tw_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_stb),
        .word  (word),
        .reg_q (reg_q)
    );

    assign wr_addr = word.addr;
    assign wr_data = word.data;

endmodule

// File: tb/tw_ctl_slave_tb.sv
module tw_ctl_slave_tb;

    localparam int NR = 16;
    localparam int T  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          addr_sel = 1'b0;
    logic          sda_oe;
    logic          wr_stb;
    logic [6:0]    wr_addr;
    logic [8:0]    wr_data;
    logic [NR*9-1:0] reg_q;
    logic          sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int stb_cnt = 0;
    int stb_wide = 0;
    logic          stb_prev = 1'b0;
    logic [6:0]    last_addr = '0;
    logic [8:0]    last_data = '0;
    logic [8:0]    exp_reg [NR];

    assign sda_bus = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    tw_ctl_slave #(.NUM_REGS(NR)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .addr_sel (addr_sel),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .reg_q    (reg_q)
    );

    always @(posedge clk) begin
        if (!rst && wr_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
        if (!rst && wr_stb && stb_prev) stb_wide <= stb_wide + 1;
        stb_prev <= wr_stb;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start_c();
        m_sda = 1'b1; wc(T);
        m_scl = 1'b1; wc(T);
        m_sda = 1'b0; wc(T);
        m_scl = 1'b0; wc(T);
    endtask

    task automatic stop_c();
        m_sda = 1'b0; wc(T);
        m_scl = 1'b1; wc(T);
        m_sda = 1'b1; wc(T);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wc(T);
            m_scl = 1'b1; wc(T);
            m_scl = 1'b0; wc(T);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        m_sda = 1'b1; wc(T);
        m_scl = 1'b1; wc(T);
        acked = (sda_bus == 1'b0);
        m_scl = 1'b0; wc(T);
    endtask

    task automatic xfer(input logic [7:0] dev, input logic [15:0] w, output int acks);
        bit a;
        acks = 0;
        start_c();
        send_byte(dev, a);
        if (a) begin
            acks++;
            send_byte(w[15:8], a); if (a) acks++;
            send_byte(w[7:0], a);  if (a) acks++;
        end
        stop_c();
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NR; i++)
            check(reg_q[i*9 +: 9] == exp_reg[i], req, int'(reg_q[i*9 +: 9]), int'(exp_reg[i]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int acks;
        int s0;
        bit a;
        for (int i = 0; i < NR; i++) exp_reg[i] = '0;
        wc(5);
        // R1: reset state
        check(reg_q == '0, "R1 bank", 0, 0);
        check(sda_oe == 1'b0, "R1 oe", int'(sda_oe), 0);
        check(wr_stb == 1'b0, "R1 stb", int'(wr_stb), 0);
        rst = 1'b0; wc(4);

        // R4/R5: sweep all device addresses under both strap values
        for (int s = 0; s < 2; s++) begin
            addr_sel = s[0];
            for (int d = 0; d < 128; d++) begin
                start_c();
                send_byte({d[6:0], 1'b0}, a);
                check(a == (d == (26 + s)), (d == 26 + s) ? "R4 match ack" : "R5 no ack",
                      int'(a), int'(d == 26 + s));
                wc(T);
                check(sda_oe == 1'b0, "R4 ack release", int'(sda_oe), 0);
                stop_c();
            end
            // R5: direction bit 1 is refused
            start_c();
            send_byte({7'(26 + s), 1'b1}, a);
            check(!a, "R5 read bit", int'(a), 0);
            stop_c();
        end
        check(stb_cnt == 0, "R5 no strobe in sweep", stb_cnt, 0);

        // R2/R6/R7/R8: write every register, data computed from index
        addr_sel = 1'b0;
        for (int i = 0; i < NR; i++) begin
            logic [8:0] dv;
            dv = 9'((i * 53 + 7) % 512);
            s0 = stb_cnt;
            xfer(8'h34, {7'(i), dv}, acks);
            exp_reg[i] = dv;
            check(acks == 3, "R6 three acks", acks, 3);
            check(stb_cnt == s0 + 1, "R7 one strobe", stb_cnt - s0, 1);
            check(last_addr == 7'(i), "R7 addr field", int'(last_addr), i);
            check(last_data == dv, "R2 msb first data", int'(last_data), int'(dv));
        end
        check_bank("R8 full bank");

        // R4: strap high, address 0011011
        addr_sel = 1'b1;
        xfer(8'h36, {7'd3, 9'h1A5}, acks);
        exp_reg[3] = 9'h1A5;
        check(acks == 3, "R4 strap high", acks, 3);
        check_bank("R8 strap high write");
        xfer(8'h34, {7'd4, 9'h0AA}, acks);
        check(acks == 0, "R4 old address refused", acks, 0);
        check_bank("R5 refused write");

        // R8: out-of-range register address
        s0 = stb_cnt;
        xfer(8'h36, {7'd100, 9'h1FF}, acks);
        check(stb_cnt == s0 + 1, "R8 strobe out of range", stb_cnt - s0, 1);
        check_bank("R8 out of range ignored");

        // R5: wrong device followed by data bytes
        s0 = stb_cnt;
        start_c();
        send_byte(8'h30, a); check(!a, "R5 wrong dev", int'(a), 0);
        send_byte(8'h0A, a); check(!a, "R5 later byte", int'(a), 0);
        send_byte(8'h55, a); check(!a, "R5 last byte", int'(a), 0);
        stop_c();
        check(stb_cnt == s0, "R5 no strobe", stb_cnt - s0, 0);
        check_bank("R5 bank");

        // R3: stop mid second byte
        s0 = stb_cnt;
        start_c();
        send_byte(8'h36, a);
        send_bits(8'h0E, 4);
        m_scl = 1'b0;
        stop_c();
        check(stb_cnt == s0, "R3 stop abort", stb_cnt - s0, 0);
        check_bank("R3 stop abort bank");

        // R3: repeated start after acknowledged second byte
        start_c();
        send_byte(8'h36, a);
        send_byte(8'h0A, a);
        check(a, "R6 second ack", int'(a), 1);
        start_c();
        send_byte(8'h33, a);
        check(!a, "R3 idle after start", int'(a), 0);
        stop_c();
        check(stb_cnt == s0, "R3 start abort", stb_cnt - s0, 0);
        check_bank("R3 start abort bank");

        // R9: no start after a completed transfer
        start_c();
        send_byte(8'h36, a);
        send_byte({7'd7, 1'b1}, a);
        send_byte(8'h23, a);
        exp_reg[7] = 9'h123;
        check(stb_cnt == s0 + 1, "R9 completed", stb_cnt - s0, 1);
        send_byte(8'h36, a);
        check(!a, "R9 no ack without start", int'(a), 0);
        send_byte(8'h0C, a);
        stop_c();
        check(stb_cnt == s0 + 1, "R9 no extra strobe", stb_cnt - s0, 1);
        check_bank("R9 bank");

        check(stb_wide == 0, "R7 single-cycle strobe", stb_wide, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule